// File: doc/BRIEF.md
# Macro Engine Bitfield ALU

This block is the execute datapath of a small command-macro processor. Each issued instruction names two source registers and one destination register. Seven 32-bit general registers sit behind indices 1 to 7, and index 0 is a constant zero. The instruction selects one operation:

- a register-register ALU operation that keeps a carry flag between instructions,
- an add of a sign-extended 18-bit immediate,
- a bitfield merge,
- one of two bitfield extract-and-shift forms, in which one bit position comes from a register.

The result leaves the block on a registered scratch output for the assignment stage that follows. When the instruction asks for it, the same result is also written back to the destination register.

Instruction decode, fetch, branching and parameter handling happen upstream. The caller presents already-decoded fields together with a one-cycle issue strobe. A new instruction can be issued on every cycle. A write from one instruction is seen by the instruction issued on the next cycle.

Top module: `mbf_alu_top`

## Requirements
- R1: Source index 0 always reads as zero. A write-back addressed to index 0 is discarded. Example: OR of r0 with r0 returns 0 even after a write to r0.
- R2: A write-back (`in_wr`=1) to index 1..7 stores the result, and the instruction issued on the next cycle reads the new value.
- R3: With operation code 0, function 0 (ADD) returns x+y modulo 2^32 and sets carry when the result is below x. Function 1 (ADDC) returns x+y+carry and sets carry by the same rule.
- R4: Function 2 (SUB) returns x−y and sets carry when the result is above x. Function 3 (SUBB) returns x−y−carry and sets carry by the same rule.
- R5: Functions 4 to 8 are the logical operations XOR, OR, AND, x AND NOT y, and NOT(x AND y), in that order. None of them changes carry.
- R6: Operation code 1 returns x plus the 18-bit immediate, sign-extended to 32 bits. Operation codes 1 to 4 leave carry unchanged.
- R7: Operation code 2 (merge) starts from x. It replaces the `size` bits at `dst_bit` with the `size` bits of y that start at `src_bit`. Bits that would fall above bit 31 are dropped.
- R8: Operation code 3 shifts the field of y that starts at bit position x to `dst_bit`. Operation code 4 shifts the field of y that starts at `src_bit` to bit position x. In both forms the result is 0 when either position exceeds 31.
- R9: A `size` of 0 selects an empty field. Merge then returns x unchanged, and both extract-shift forms return 0.
- R10: The result and `out_valid` appear on the clock edge after `in_valid`. A cycle without `in_valid` drops `out_valid` and leaves carry and the registers untouched.
- R11: Synchronous reset clears carry, `out_valid` and all seven registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue strobe for the decoded instruction |
| in_op | input | 3 | Operation code (0 ALU, 1 add-immediate, 2 merge, 3 extract-shift source from register, 4 extract-shift destination from register) |
| in_fn | input | 4 | ALU function for operation code 0 |
| in_src_a | input | 3 | Register index of x |
| in_src_b | input | 3 | Register index of y |
| in_dst | input | 3 | Destination register index |
| in_wr | input | 1 | Write the result back to `in_dst` |
| in_imm | input | 18 | Signed immediate |
| in_src_bit | input | 5 | Field source bit position |
| in_dst_bit | input | 5 | Field destination bit position |
| in_size | input | 5 | Field width in bits |
| out_valid | output | 1 | Scratch result is valid |
| out_data | output | 32 | Scratch result |
| carry_o | output | 1 | Current carry flag |

## Verification
In one cycle, a single instruction both updates the carry flag and writes its result to a register. A following ADDC or SUBB then depends on both effects at once.

The bench provokes this in two ways. It chains arithmetic instructions back to back, with each destination being a source of the next. It also aims a carry-producing instruction at index 0, so the carry must change while the write is dropped.

A behavioural model keeps its own register array and carry bit. Every cycle, the model's expected result and carry are compared with `out_data` and `carry_o`.

// File: rtl/mbf_pkg.sv
package mbf_pkg;
    localparam int XLEN   = 32;
    localparam int NREG   = 8;
    localparam int IMM_W  = 18;
    localparam int RIDX_W = $clog2(NREG);
    localparam int POS_W  = $clog2(XLEN);

    typedef enum logic [2:0] {
        OPC_ALU     = 3'd0,
        OPC_ADDI    = 3'd1,
        OPC_MERGE   = 3'd2,
        OPC_BFE_SRX = 3'd3,
        OPC_BFE_DRX = 3'd4
    } opc_e;

    typedef enum logic [3:0] {
        FN_ADD  = 4'd0,
        FN_ADDC = 4'd1,
        FN_SUB  = 4'd2,
        FN_SUBB = 4'd3,
        FN_XOR  = 4'd4,
        FN_OR   = 4'd5,
        FN_AND  = 4'd6,
        FN_ANDN = 4'd7,
        FN_NAND = 4'd8
    } alu_fn_e;

    typedef enum logic [1:0] {
        BF_MERGE = 2'd0,
        BF_SRX   = 2'd1,
        BF_DRX   = 2'd2
    } bf_mode_e;

    typedef struct packed {
        opc_e               opc;
        alu_fn_e            fn;
        logic [RIDX_W-1:0]  ra;
        logic [RIDX_W-1:0]  rb;
        logic [RIDX_W-1:0]  rd;
        logic               wr;
        logic [IMM_W-1:0]   imm;
        logic [POS_W-1:0]   sbit;
        logic [POS_W-1:0]   dbit;
        logic [POS_W-1:0]   size;
    } instr_t;

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
    endfunction
endpackage

// File: rtl/mbf_regfile.sv
module mbf_regfile #(
    parameter int W  = mbf_pkg::XLEN,
    parameter int N  = mbf_pkg::NREG,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] ra,
    input  logic [IW-1:0] rb,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b,
    input  logic          we,
    input  logic [IW-1:0] wa,
    input  logic [W-1:0]  wd
);
    logic [W-1:0] regs [0:N-1];

    always_ff @(posedge clk) begin
        regs[0] <= '0;
        for (int i = 1; i < N; i++) begin
            if (rst) begin
                regs[i] <= '0;
            end else if (we && wa == IW'(i)) begin
                regs[i] <= wd;
            end
        end
    end

    assign rdata_a = (ra == '0) ? '0 : regs[ra];
    assign rdata_b = (rb == '0) ? '0 : regs[rb];
endmodule

// File: rtl/mbf_arith.sv
module mbf_arith #(
    parameter int W = mbf_pkg::XLEN
) (
    input  mbf_pkg::alu_fn_e fn,
    input  logic [W-1:0]     x,
    input  logic [W-1:0]     y,
    input  logic             cin,
    output logic [W-1:0]     res,
    output logic             cout,
    output logic             cupd
);
    import mbf_pkg::*;

    logic [W-1:0] cext;
    assign cext = {{(W-1){1'b0}}, cin};

    always_comb begin
        res  = '0;
        cout = cin;
        cupd = 1'b0;
        case (fn)
            FN_ADD:  begin res = x + y;        cout = (res < x); cupd = 1'b1; end
            FN_ADDC: begin res = x + y + cext; cout = (res < x); cupd = 1'b1; end
            FN_SUB:  begin res = x - y;        cout = (res > x); cupd = 1'b1; end
            FN_SUBB: begin res = x - y - cext; cout = (res > x); cupd = 1'b1; end
            FN_XOR:  res = x ^ y;
            FN_OR:   res = x | y;
            FN_AND:  res = x & y;
            FN_ANDN: res = x & ~y;
            FN_NAND: res = ~(x & y);
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/mbf_bitfield.sv
module mbf_bitfield #(
    parameter int W  = mbf_pkg::XLEN,
    localparam int PW = $clog2(W)
) (
    input  mbf_pkg::bf_mode_e mode,
    input  logic [W-1:0]      x,
    input  logic [W-1:0]      y,
    input  logic [PW-1:0]     sbit,
    input  logic [PW-1:0]     dbit,
    input  logic [PW-1:0]     size,
    output logic [W-1:0]      res
);
    import mbf_pkg::*;

    logic [W:0]    mask_wide;
    logic [W-1:0]  mask;
    logic [W-1:0]  spos, dpos;
    logic          out_of_range;
    logic [W-1:0]  field;

    // One bit wider than the datapath so that no size can overflow the mask
    assign mask_wide = ((W+1)'(1) << size) - (W+1)'(1);
    assign mask      = mask_wide[W-1:0];

    always_comb begin
        spos = {{(W-PW){1'b0}}, sbit};
        dpos = {{(W-PW){1'b0}}, dbit};
        if (mode == BF_SRX) spos = x;
        if (mode == BF_DRX) dpos = x;
    end

    assign out_of_range = (|spos[W-1:PW]) || (|dpos[W-1:PW]);
    assign field        = ((y >> spos[PW-1:0]) & mask) << dpos[PW-1:0];

    always_comb begin
        if (mode == BF_MERGE) begin
            res = (x & ~(mask << dbit)) | field;
        end else begin
            res = out_of_range ? '0 : field;
        end
    end
endmodule

// File: rtl/mbf_alu_top.sv
module mbf_alu_top #(
    parameter int W     = mbf_pkg::XLEN,
    parameter int NREG  = mbf_pkg::NREG,
    parameter int IMM_W = mbf_pkg::IMM_W,
    localparam int IW   = $clog2(NREG),
    localparam int PW   = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [2:0]       in_op,
    input  logic [3:0]       in_fn,
    input  logic [IW-1:0]    in_src_a,
    input  logic [IW-1:0]    in_src_b,
    input  logic [IW-1:0]    in_dst,
    input  logic             in_wr,
    input  logic [IMM_W-1:0] in_imm,
    input  logic [PW-1:0]    in_src_bit,
    input  logic [PW-1:0]    in_dst_bit,
    input  logic [PW-1:0]    in_size,
    output logic             out_valid,
    output logic [W-1:0]     out_data,
    output logic             carry_o
);
    import mbf_pkg::*;

    instr_t       ins;
    logic [W-1:0] x_val, y_val;
    logic [W-1:0] alu_res, bf_res, result;
    logic         alu_cout, alu_cupd;
    logic         carry_q;
    bf_mode_e     bf_mode;
    logic [W-1:0] simm;

    always_comb begin
        ins      = '0;
        ins.opc  = opc_e'(in_op);
        ins.fn   = alu_fn_e'(in_fn);
        ins.ra   = in_src_a;
        ins.rb   = in_src_b;
        ins.rd   = in_dst;
        ins.wr   = in_wr;
        ins.imm  = in_imm;
        ins.sbit = in_src_bit;
        ins.dbit = in_dst_bit;
        ins.size = in_size;
    end

    mbf_regfile #(.W(W), .N(NREG)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .ra      (ins.ra),
        .rb      (ins.rb),
        .rdata_a (x_val),
        .rdata_b (y_val),
        .we      (in_valid && ins.wr),
        .wa      (ins.rd),
        .wd      (result)
    );

    mbf_arith #(.W(W)) u_arith (
        .fn   (ins.fn),
        .x    (x_val),
        .y    (y_val),
        .cin  (carry_q),
        .res  (alu_res),
        .cout (alu_cout),
        .cupd (alu_cupd)
    );

    always_comb begin
        case (ins.opc)
            OPC_BFE_SRX: bf_mode = BF_SRX;
            OPC_BFE_DRX: bf_mode = BF_DRX;
            default:     bf_mode = BF_MERGE;
        endcase
    end

    mbf_bitfield #(.W(W)) u_bf (
        .mode (bf_mode),
        .x    (x_val),
        .y    (y_val),
        .sbit (ins.sbit),
        .dbit (ins.dbit),
        .size (ins.size),
        .res  (bf_res)
    );

    assign simm = {{(W-IMM_W){ins.imm[IMM_W-1]}}, ins.imm};

    always_comb begin
        case (ins.opc)
            OPC_ALU:                          result = alu_res;
            OPC_ADDI:                         result = x_val + simm;
            OPC_MERGE, OPC_BFE_SRX, OPC_BFE_DRX: result = bf_res;
            default:                          result = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            carry_q   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= result;
                if (ins.opc == OPC_ALU && alu_cupd) carry_q <= alu_cout;
            end
        end
    end

    assign carry_o = carry_q;
endmodule

// File: rtl/mbf_alu_chk.sv
module mbf_alu_chk #(
    parameter int W  = 32,
    localparam int PW = $clog2(W)
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [2:0]   in_op,
    input logic [3:0]   in_fn,
    input logic [2:0]   in_src_a,
    input logic [2:0]   in_src_b,
    input logic [W-1:0] x_val,
    input logic         out_valid,
    input logic [W-1:0] out_data,
    input logic         carry_o
);
    // R11: reset clears the flag and the valid
    a_r11_reset_state: assert property (@(posedge clk)
        rst |=> (!out_valid && !carry_o));

    // R10: idle cycle drops valid and keeps carry
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(carry_o)));

    // R10: issue gives a valid one edge later
    a_r10_issue_valid: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R5: logical functions keep carry
    a_r5_logic_carry: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 3'd0 && in_fn >= 4'd4) |=> $stable(carry_o));

    // R6: non-ALU operations keep carry
    a_r6_other_carry: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op != 3'd0) |=> $stable(carry_o));

    // R8: register-supplied source position above 31 yields zero
    a_r8_range_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 3'd3 && (|x_val[W-1:PW])) |=> (out_data == '0));

    // R1: zero register read through OR
    a_r1_zero_read: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 3'd0 && in_fn == 4'd5 && in_src_a == 3'd0 && in_src_b == 3'd0)
        |=> (out_data == '0));
endmodule

bind mbf_alu_top mbf_alu_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .in_fn     (in_fn),
    .in_src_a  (in_src_a),
    .in_src_b  (in_src_b),
    .x_val     (x_val),
    .out_valid (out_valid),
    .out_data  (out_data),
    .carry_o   (carry_o)
);

// File: tb/mbf_alu_top_tb.sv
`timescale 1ns/1ps
module mbf_alu_top_tb_top;
    localparam real TCLK = 8.0;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [2:0]  in_op;
    logic [3:0]  in_fn;
    logic [2:0]  in_src_a, in_src_b, in_dst;
    logic        in_wr;
    logic [17:0] in_imm;
    logic [4:0]  in_src_bit, in_dst_bit, in_size;
    logic        out_valid;
    logic [31:0] out_data;
    logic        carry_o;

    int n_cmp = 0;
    int n_bad = 0;

    // reference state
    logic [31:0] mregs [8];
    bit          mcarry;

    always #(TCLK/2) clk = ~clk;

    mbf_alu_top dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_fn(in_fn),
        .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst), .in_wr(in_wr),
        .in_imm(in_imm), .in_src_bit(in_src_bit), .in_dst_bit(in_dst_bit),
        .in_size(in_size), .out_valid(out_valid), .out_data(out_data), .carry_o(carry_o)
    );

    function automatic logic [31:0] ref_field(input logic [31:0] y, input longint s,
                                               input longint d, input int sz);
        logic [31:0] r = 32'h0;
        if (s > 31 || d > 31) return 32'h0;
        for (int i = 0; i < sz; i++)
            if (s + i < 32 && d + i < 32) r[d+i] = y[s+i];
        return r;
    endfunction

    function automatic logic [31:0] ref_merge(input logic [31:0] x, input logic [31:0] y,
                                               input int s, input int d, input int sz);
        logic [31:0] r = x;
        for (int i = 0; i < sz; i++)
            if (d + i < 32) r[d+i] = (s + i < 32) ? y[s+i] : 1'b0;
        return r;
    endfunction

    task automatic predict(output logic [31:0] r, output bit c);
        logic [31:0] x, y;
        longint sum;
        x = mregs[in_src_a];
        y = mregs[in_src_b];
        c = mcarry;
        r = 32'h0;
        case (in_op)
            3'd0: case (in_fn)
                4'd0: begin sum = longint'(x) + longint'(y); r = sum[31:0]; c = (r < x); end
                4'd1: begin sum = longint'(x) + longint'(y) + longint'(mcarry); r = sum[31:0]; c = (r < x); end
                4'd2: begin sum = longint'(x) - longint'(y); r = sum[31:0]; c = (r > x); end
                4'd3: begin sum = longint'(x) - longint'(y) - longint'(mcarry); r = sum[31:0]; c = (r > x); end
                4'd4: r = x ^ y;
                4'd5: r = x | y;
                4'd6: r = x & y;
                4'd7: r = x & ~y;
                4'd8: r = ~(x & y);
                default: r = 32'h0;
            endcase
            3'd1: begin
                sum = longint'(x) + (in_imm[17] ? longint'(in_imm) - 262144 : longint'(in_imm));
                r = sum[31:0];
            end
            3'd2: r = ref_merge(x, y, int'(in_src_bit), int'(in_dst_bit), int'(in_size));
            3'd3: r = ref_field(y, longint'(x), longint'(in_dst_bit), int'(in_size));
            3'd4: r = ref_field(y, longint'(in_src_bit), longint'(x), int'(in_size));
            default: r = 32'h0;
        endcase
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic issue(input logic [2:0] op, input logic [3:0] fn, input logic [2:0] a,
                         input logic [2:0] b, input logic [2:0] d, input logic wr,
                         input logic [17:0] imm, input logic [4:0] sb, input logic [4:0] db,
                         input logic [4:0] sz, input string tag);
        logic [31:0] er;
        bit ec;
        in_valid = 1'b1; in_op = op; in_fn = fn; in_src_a = a; in_src_b = b;
        in_dst = d; in_wr = wr; in_imm = imm; in_src_bit = sb; in_dst_bit = db; in_size = sz;
        predict(er, ec);
        if (wr && d != 3'd0) mregs[d] = er;
        mcarry = ec;
        @(posedge clk); #2;
        n_cmp++;
        if (out_valid !== 1'b1 || out_data !== er || carry_o !== ec) begin
            n_bad++;
            $display("FAIL %s op=%0d fn=%0d: valid=%b data=%h carry=%b expected valid=1 data=%h carry=%b",
                     tag, op, fn, out_valid, out_data, carry_o, er, ec);
        end
        @(negedge clk);
    endtask

    task automatic idle(input string tag);
        in_valid = 1'b0;
        in_op = $urandom_range(0, 4);
        in_wr = 1'b1;
        in_dst = $urandom_range(1, 7);
        @(posedge clk); #2;
        n_cmp++;
        if (out_valid !== 1'b0 || carry_o !== mcarry) begin
            n_bad++;
            $display("FAIL %s idle: valid=%b carry=%b expected valid=0 carry=%b",
                     tag, out_valid, carry_o, mcarry);
        end
        @(negedge clk);
    endtask

    function automatic string tag_of(input logic [2:0] op, input logic [3:0] fn);
        if (op == 3'd0) return (fn < 4'd2) ? "R3" : (fn < 4'd4) ? "R4" : "R5";
        if (op == 3'd1) return "R6";
        if (op == 3'd2) return "R7";
        return "R8";
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R10 watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) mregs[i] = 32'h0;
        mcarry = 1'b0;
        rst = 1'b1; in_valid = 1'b0; in_op = 3'd0; in_fn = 4'd0; in_src_a = 3'd0;
        in_src_b = 3'd0; in_dst = 3'd0; in_wr = 1'b0; in_imm = 18'h0;
        in_src_bit = 5'd0; in_dst_bit = 5'd0; in_size = 5'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_cmp++;
        if (out_valid !== 1'b0 || carry_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R11 reset: valid=%b carry=%b expected valid=0 carry=0", out_valid, carry_o);
        end
        rst = 1'b0;
        // R11: every register reads zero after reset
        for (int r = 0; r < 8; r++) issue(3'd0, 4'd5, 3'(r), 3'd0, 3'd0, 1'b0, 18'h0, 5'd0, 5'd0, 5'd0, "R11");

        // R6: sign-extended immediates
        issue(3'd1, 4'd0, 3'd0, 3'd0, 3'd1, 1'b1, 18'h3FFFF, 5'd0, 5'd0, 5'd0, "R6");
        issue(3'd1, 4'd0, 3'd0, 3'd0, 3'd2, 1'b1, 18'h00001, 5'd0, 5'd0, 5'd0, "R6");
        issue(3'd1, 4'd0, 3'd0, 3'd0, 3'd3, 1'b1, 18'h1FFFF, 5'd0, 5'd0, 5'd0, "R6");
        issue(3'd1, 4'd0, 3'd3, 3'd0, 3'd3, 1'b1, 18'h20000, 5'd0, 5'd0, 5'd0, "R6");
        // R3 / R4: carry chains, each result feeding the next
        issue(3'd0, 4'd0, 3'd1, 3'd2, 3'd4, 1'b1, 18'h0, 5'd0, 5'd0, 5'd0, "R3");
        issue(3'd0, 4'd1, 3'd2, 3'd4, 3'd5, 1'b1, 18'h0, 5'd0, 5'd0, 5'd0, "R3");
        issue(3'd0, 4'd1, 3'd1, 3'd1, 3'd5, 1'b1, 18'h0, 5'd0, 5'd0, 5'd0, "R3");
        issue(3'd0, 4'd1, 3'd5, 3'd1, 3'd5, 1'b1, 18'h0, 5'd0, 5'd0, 5'd0, "R3");
        issue(3'd0, 4'd2, 3'd0, 3'd2, 3'd6, 1'b1, 18'h0, 5'd0, 5'd0, 5'd0, "R4");
        issue(3'd0, 4'd3, 3'd2, 3'd0, 3'd7, 1'b1, 18'h0, 5'd0, 5'd0, 5'd0, "R4");
        issue(3'd0, 4'd3, 3'd0, 3'd0, 3'd7, 1'b1, 18'h0, 5'd0, 5'd0, 5'd0, "R4");
        issue(3'd0, 4'd3, 3'd7, 3'd2, 3'd6, 1'b1, 18'h0, 5'd0, 5'd0, 5'd0, "R4");
        // R1: carry-producing write aimed at r0, then r0 read back
        issue(3'd0, 4'd0, 3'd1, 3'd1, 3'd0, 1'b1, 18'h0, 5'd0, 5'd0, 5'd0, "R1");
        issue(3'd0, 4'd5, 3'd0, 3'd0, 3'd0, 1'b0, 18'h0, 5'd0, 5'd0, 5'd0, "R1");
        issue(3'd1, 4'd0, 3'd0, 3'd0, 3'd0, 1'b1, 18'h00005, 5'd0, 5'd0, 5'd0, "R1");
        issue(3'd1, 4'd0, 3'd0, 3'd0, 3'd4, 1'b1, 18'h0, 5'd0, 5'd0, 5'd0, "R1");
        // R5: logical ops with carry set
        for (int f = 4; f <= 8; f++) issue(3'd0, 4'(f), 3'd1, 3'd3, 3'd4, 1'b1, 18'h0, 5'd0, 5'd0, 5'd0, "R5");
        // R7 / R9: merge
        issue(3'd2, 4'd0, 3'd1, 3'd2, 3'd5, 1'b1, 18'h0, 5'd0, 5'd8, 5'd4, "R7");
        issue(3'd2, 4'd0, 3'd0, 3'd3, 3'd5, 1'b1, 18'h0, 5'd12, 5'd28, 5'd9, "R7");
        issue(3'd2, 4'd0, 3'd1, 3'd2, 3'd5, 1'b1, 18'h0, 5'd0, 5'd8, 5'd0, "R9");
        // R8 / R9: extract-shift
        issue(3'd1, 4'd0, 3'd0, 3'd0, 3'd3, 1'b1, 18'h1FFFF, 5'd0, 5'd0, 5'd0, "R8");
        issue(3'd3, 4'd0, 3'd2, 3'd3, 3'd6, 1'b1, 18'h0, 5'd0, 5'd4, 5'd8, "R8");
        issue(3'd3, 4'd0, 3'd1, 3'd3, 3'd6, 1'b1, 18'h0, 5'd0, 5'd4, 5'd8, "R8");
        issue(3'd4, 4'd0, 3'd2, 3'd3, 3'd6, 1'b1, 18'h0, 5'd16, 5'd0, 5'd2, "R8");
        issue(3'd4, 4'd0, 3'd1, 3'd3, 3'd6, 1'b1, 18'h0, 5'd16, 5'd0, 5'd2, "R8");
        issue(3'd4, 4'd0, 3'd2, 3'd3, 3'd6, 1'b1, 18'h0, 5'd1, 5'd0, 5'd31, "R8");
        issue(3'd3, 4'd0, 3'd2, 3'd3, 3'd6, 1'b1, 18'h0, 5'd0, 5'd4, 5'd0, "R9");
        issue(3'd4, 4'd0, 3'd2, 3'd3, 3'd6, 1'b1, 18'h0, 5'd3, 5'd0, 5'd0, "R9");
        // R10: idle cycles leave state alone
        for (int k = 0; k < 3; k++) idle("R10");
        issue(3'd0, 4'd1, 3'd0, 3'd0, 3'd0, 1'b0, 18'h0, 5'd0, 5'd0, 5'd0, "R10");
        // R2: back-to-back dependency
        issue(3'd1, 4'd0, 3'd0, 3'd0, 3'd4, 1'b1, 18'h00007, 5'd0, 5'd0, 5'd0, "R2");
        issue(3'd1, 4'd0, 3'd4, 3'd0, 3'd5, 1'b1, 18'h00001, 5'd0, 5'd0, 5'd0, "R2");
        issue(3'd0, 4'd0, 3'd5, 3'd4, 3'd5, 1'b1, 18'h0, 5'd0, 5'd0, 5'd0, "R2");
        // random mix, occasional idle cycles
        for (int n = 0; n < 600; n++) begin
            logic [2:0] op;
            logic [3:0] fn;
            op = 3'($urandom_range(0, 4));
            fn = 4'($urandom_range(0, 8));
            if ($urandom_range(0, 9) == 0) idle("R10");
            else issue(op, fn, 3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)),
                       3'($urandom_range(0, 7)), ($urandom_range(0, 3) != 0),
                       18'($urandom), 5'($urandom), 5'($urandom),
                       5'($urandom), tag_of(op, fn));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule